// File: doc/BRIEF.md
# Duty-Limited Pulse Repeater

This block regenerates pulses on one channel. An asynchronous trigger line passes through a synchroniser, and its rising edges are detected. Each edge that is accepted starts an output pulse. After the output pulse ends, a guard interval starts. The guard interval keeps the long-run output duty cycle at or below one part in `DUTY_DIV`. A rising edge that appears while a pulse is being driven, or during the guard interval, produces no output. It raises a one-cycle `miss_o` strobe instead, which the host logic can accumulate into a sticky error flag.

A compile-time switch selects the pulse shape:
- With `FIXED_WIDTH = 1`, every pulse lasts exactly `PULSE_W` clock cycles. `PULSE_W` ranges from 20 to 40 and defaults to 24, which is 1.2 µs at 20 MHz.
- With `FIXED_WIDTH = 0`, the output follows the synchronised trigger level. It is cut off at `PULSE_W` cycles.

The guard interval always lasts `PULSE_W * (DUTY_DIV - 1)` cycles. The enable input parks the block whenever it is low.

The control is a three-state machine:
- **IDLE**: waiting for an edge. An enabled edge moves to **DRIVE**.
- **DRIVE**: the output is high. The machine moves to **GUARD** when the width count reaches `PULSE_W`, or, in follow mode, when the level drops. It moves straight to IDLE if the guard length is zero.
- **GUARD**: the output is low and edges are rejected. The machine returns to IDLE when the guard count expires.

A low enable forces IDLE from any state.

Top module: `pulse_repeater`

## Requirements
- R1: While reset is asserted and after it is released, `pulse_o` and `miss_o` are low and the machine is in IDLE.
- R2: A rising edge on `trig_a_i` that is set up before clock edge k is accepted at edge k+2 (two synchroniser stages plus the edge register). `pulse_o` is high after edge k+2.
- R3: With `FIXED_WIDTH = 1`, each output pulse is high for exactly `PULSE_W` clock cycles, whatever the trigger does meanwhile.
- R4: After a pulse ends, a guard interval of `PULSE_W*(DUTY_DIV-1)` cycles follows.
  - An edge sampled in the last guard cycle is not accepted.
  - An edge sampled one cycle later is accepted.
- R5: An enabled rising edge sampled in DRIVE or GUARD raises `miss_o` for exactly one cycle. No new pulse follows from it.
- R6: When `en_i` is low, the machine returns to IDLE at the next edge, `pulse_o` is low from then on, and edges raise neither a pulse nor `miss_o`.
- R7: With `FIXED_WIDTH = 0`, the pulse width equals the trigger high time, capped at `PULSE_W` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 20 MHz clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Channel enable; low parks the block in IDLE |
| trig_a_i | input | 1 | Asynchronous trigger input |
| pulse_o | output | 1 | Regenerated output pulse |
| miss_o | output | 1 | One-cycle strobe for each rejected trigger edge |

## Verification
The hardest case to reach from the ports is an edge that lands exactly on the last cycle of the guard interval, or on the first cycle after it. Reaching it needs a count of the three-register input latency together with the pulse width and the guard length. The stimulus fires a reference pulse, keeps the trigger low, and raises it again a computed number of cycles later. It does this twice: once so that the edge is sampled in the final GUARD cycle, and once shifted by one cycle so that it is sampled in the first IDLE cycle.

// File: rtl/pulse_repeater_pkg.sv
package pulse_repeater_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_GUARD = 2'd2
    } rep_state_t;

endpackage

// File: rtl/pulse_repeater_sync.sv
module pulse_repeater_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pulse_repeater_fsm.sv
module pulse_repeater_fsm
    import pulse_repeater_pkg::*;
#(
    parameter bit FIXED_WIDTH = 1'b1,
    parameter int PULSE_W     = 24,
    parameter int DUTY_DIV    = 5
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic level_i,
    input  logic rise_i,
    output logic pulse_o,
    output logic miss_o
);
    localparam int GUARD_LEN = PULSE_W * (DUTY_DIV - 1);
    localparam int MAX_LEN   = (GUARD_LEN > PULSE_W) ? GUARD_LEN : PULSE_W;
    localparam int CW        = $clog2(MAX_LEN + 1);

    rep_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          drive_done;

    generate
        if (FIXED_WIDTH) begin : g_fixed
            assign drive_done = (cnt_q == CW'(PULSE_W - 1));
        end else begin : g_follow
            assign drive_done = (cnt_q == CW'(PULSE_W - 1)) || !level_i;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (en_i && rise_i) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (drive_done) begin
                    cnt_d   = '0;
                    state_d = (GUARD_LEN == 0) ? ST_IDLE : ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (cnt_q == CW'(GUARD_LEN - 1)) begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
        if (!en_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse_o = 1'b0;
        miss_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DRIVE: begin
                pulse_o = 1'b1;
                miss_o  = en_i && rise_i;
            end
            ST_GUARD: miss_o = en_i && rise_i;
            default:  ;
        endcase
    end

    // R3
    drive_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_DRIVE) |-> (cnt_q < CW'(PULSE_W)));

    // R4
    no_restart_in_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_GUARD) |=> (state_q != ST_DRIVE));

    // R5
    miss_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        miss_o |=> !miss_o);

    // R6
    disabled_parks_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |=> (state_q == ST_IDLE) && !pulse_o);

    // R2
    start_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(pulse_o) |-> $past(rise_i && en_i));

endmodule

// File: rtl/pulse_repeater.sv
module pulse_repeater #(
    parameter bit FIXED_WIDTH = 1'b1,
    parameter int PULSE_W     = 24,
    parameter int DUTY_DIV    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic trig_a_i,
    output logic pulse_o,
    output logic miss_o
);
    logic trig_level;
    logic trig_rise;

    pulse_repeater_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i (trig_a_i),
        .level_o (trig_level),
        .rise_o  (trig_rise)
    );

    pulse_repeater_fsm #(
        .FIXED_WIDTH (FIXED_WIDTH),
        .PULSE_W     (PULSE_W),
        .DUTY_DIV    (DUTY_DIV)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (en_i),
        .level_i (trig_level),
        .rise_i  (trig_rise),
        .pulse_o (pulse_o),
        .miss_o  (miss_o)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> !pulse_o && !miss_o);

endmodule

// File: tb/sim_pulse_repeater.sv
module sim_pulse_repeater;
    localparam int W0 = 24;
    localparam int D0 = 5;
    localparam int G0 = W0 * (D0 - 1);
    localparam int W1 = 8;
    localparam int D1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic trig0 = 1'b0;
    logic trig1 = 1'b0;
    logic pulse0, miss0, pulse1, miss1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int stp = 0;
    int hi0 = 0;
    int ms0 = 0;
    int hi1 = 0;
    int first0 = -1;
    int miss_at = -1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_repeater #(.FIXED_WIDTH(1'b1), .PULSE_W(W0), .DUTY_DIV(D0)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .en_i(en), .trig_a_i(trig0),
        .pulse_o(pulse0), .miss_o(miss0));

    pulse_repeater #(.FIXED_WIDTH(1'b0), .PULSE_W(W1), .DUTY_DIV(D1)) u1 (
        .clk_i(clk), .rst_n_i(rst_n), .en_i(1'b1), .trig_a_i(trig1),
        .pulse_o(pulse1), .miss_o(miss1));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_acc();
        stp = 0; hi0 = 0; ms0 = 0; hi1 = 0; first0 = -1; miss_at = -1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        stp++;
        if (pulse0) begin
            hi0++;
            if (first0 < 0) first0 = stp;
        end
        if (miss0) begin
            ms0++;
            miss_at = stp;
        end
        if (pulse1) hi1++;
    endtask

    task automatic run_to(input int n);
        while (stp < n) step();
    endtask

    task automatic t_reset();
        check("R1 pulse after reset", int'(pulse0), 0);
        check("R1 miss after reset", int'(miss0), 0);
    endtask

    task automatic t_latency_width();
        clear_acc();
        trig0 = 1'b1;
        run_to(3);
        trig0 = 1'b0;
        run_to(W0 + G0 + 10);
        check("R2 first high step", first0, 3);
        check("R3 fixed width", hi0, W0);
        check("R3 no miss", ms0, 0);
    endtask

    task automatic t_retrigger_in_drive();
        clear_acc();
        trig0 = 1'b1;
        run_to(3);
        trig0 = 1'b0;
        run_to(6);
        trig0 = 1'b1;
        run_to(W0 + G0 + 10);
        trig0 = 1'b0;
        run_to(W0 + G0 + 14);
        check("R5 miss during drive", ms0, 1);
        check("R3 width kept on retrigger", hi0, W0);
    endtask

    task automatic t_last_guard_cycle();
        clear_acc();
        trig0 = 1'b1;
        run_to(3);
        trig0 = 1'b0;
        run_to(W0 + G0);
        trig0 = 1'b1;
        run_to(2 * (W0 + G0) + 10);
        trig0 = 1'b0;
        check("R4 edge in last guard cycle rejected", hi0, W0);
        check("R5 miss on last guard cycle", ms0, 1);
        check("R5 miss timing", miss_at, W0 + G0 + 2);
        run_to(2 * (W0 + G0) + 14);
    endtask

    task automatic t_first_idle_cycle();
        clear_acc();
        trig0 = 1'b1;
        run_to(3);
        trig0 = 1'b0;
        run_to(W0 + G0 + 1);
        trig0 = 1'b1;
        run_to(W0 + G0 + 6);
        trig0 = 1'b0;
        run_to(2 * (W0 + G0) + 10);
        check("R4 edge after guard accepted", hi0, 2 * W0);
        check("R4 no miss after guard", ms0, 0);
    endtask

    task automatic t_enable();
        clear_acc();
        en = 1'b0;
        trig0 = 1'b1;
        run_to(5);
        trig0 = 1'b0;
        run_to(10);
        trig0 = 1'b1;
        run_to(40);
        trig0 = 1'b0;
        check("R6 no pulse while disabled", hi0, 0);
        check("R6 no miss while disabled", ms0, 0);
        en = 1'b1;
        run_to(45);
        clear_acc();
        trig0 = 1'b1;
        run_to(5);
        en = 1'b0;
        trig0 = 1'b0;
        run_to(20);
        check("R6 pulse cut by disable", hi0, 3);
        en = 1'b1;
        run_to(25);
    endtask

    task automatic t_follow();
        clear_acc();
        trig1 = 1'b1;
        run_to(3);
        trig1 = 1'b0;
        run_to(40);
        check("R7 width follows input", hi1, 3);
        clear_acc();
        trig1 = 1'b1;
        run_to(20);
        trig1 = 1'b0;
        run_to(60);
        check("R7 width capped", hi1, W1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_latency_width();
        t_retrigger_in_drive();
        t_last_guard_cycle();
        t_first_idle_cycle();
        t_enable();
        t_follow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule